// File: doc/BRIEF.md
# Two-Byte-Addressed Serial Memory Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that fronts a byte-wide internal register memory. Both bus lines are oversampled by a fast system clock after a synchronizer. The block finds START and STOP conditions in the synchronized lines, and all bit-level work happens on the detected edges of the bus clock. The data line is never driven high. The block only asserts `sda_oe`, and the surrounding pad pulls the line low while that output is high.

Each transaction opens with a selection byte. Its high nibble must be the memory type code `1010`, its next three bits must equal the `sel_strap` inputs, and its least significant bit gives the direction. A write selection is followed by two pointer bytes, high byte first, and then by any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. A read selection streams bytes out from the current pointer and advances it after each byte. The stream continues until the master withholds its acknowledge. A random read is therefore a write selection with the two pointer bytes, then a repeated START and a read selection.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset `sda_oe` is 0 (data line released), and the block waits for a START.
- R2: A selection byte whose bits [7:4] equal 1010 and bits [3:1] equal `sel_strap` is acknowledged: `sda_oe` is 1 for the whole ninth bus clock. Bit [0] = 1 selects read and bit [0] = 0 selects write.
- R3: A selection byte that fails either comparison gets no acknowledge, and `sda_oe` stays 0 for the rest of that transaction.
- R4: In a write, the two bytes after the selection load pointer bits [15:8] and then [7:0]. Each following byte is stored at the pointer, and every received byte is acknowledged.
- R5: Only pointer bits [11:0] address the 4096-byte array. Bits [15:12] of the high pointer byte have no effect.
- R6: The pointer advances by one after every byte stored or sent, and it wraps from 4095 to 0.
- R7: A read selection returns the byte at the current pointer, most significant bit first, with each bit placed on the line while the bus clock is low.
- R8: A master acknowledge (line low in the ninth clock) continues the read with the next byte. A released line ends it, and `sda_oe` then stays 0 until the next START.
- R9: A START received part-way through a byte, including a repeated START, discards that byte without storing it and restarts selection-byte reception. The pointer is unchanged.
- R10: A STOP returns the block to idle. Bytes clocked in afterwards without a START are not acknowledged.
- R11: `sda_oe` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sel_strap | input | 3 | Board-strapped select bits compared with selection bits [3:1] |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with its defaults: a 12-bit array pointer (4096 bytes) and a two-stage synchronizer. The bus quarter-period is eight system clocks, so every bus-line change clears the synchronizer well before the next bus-clock edge. With the full 12-bit pointer, the wrap from 4095 to 0 can be exercised with real addresses during both sequential writes and sequential reads. The same holds for aliasing through the ignored top nibble of the high pointer byte. The straps are tied to 101, so the bench can miss the match on the type code alone or on the strap bits alone.

// File: rtl/smem_pkg.sv
package smem_pkg;
  // Bus-level phase of the slave
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RXACK,
    PH_TX,
    PH_TXACK
  } phase_t;

  // Meaning of the byte currently being received
  typedef enum logic [1:0] {
    K_SEL,
    K_PHI,
    K_PLO,
    K_DATA
  } kind_t;

  localparam logic [3:0] MEM_TYPE_CODE = 4'b1010;
endpackage

// File: rtl/smem_linecond.sv
module smem_linecond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic [STAGES-1:0] scl_ff_d, sda_ff_d;
  logic scl_prev, sda_prev;

  always_comb begin
    scl_ff_d = {scl_ff[STAGES-2:0], scl_in};
    sda_ff_d = {sda_ff[STAGES-2:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= scl_ff_d;
      sda_ff   <= sda_ff_d;
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign scl_rise   = scl_s & ~scl_prev;
  assign scl_fall   = ~scl_s & scl_prev;
  assign cond_start = scl_s & scl_prev & sda_prev & ~sda_s;
  assign cond_stop  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  // Storage array: no reset, contents are defined only by writes
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int MEM_AW      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] sel_strap,
  output logic       sda_oe
);
  import smem_pkg::*;

  localparam int HI_BITS = MEM_AW - 8;
  localparam logic [MEM_AW-1:0] PTR_ONE = 1;
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, cond_start, cond_stop;

  smem_linecond #(.STAGES(SYNC_STAGES)) u_linecond (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .cond_start(cond_start), .cond_stop(cond_stop)
  );

  phase_t              phase_q, phase_d;
  kind_t               kind_q, kind_d;
  logic [3:0]          cnt_q, cnt_d;
  logic [7:0]          rx_q, rx_d;
  logic [7:0]          tx_q, tx_d;
  logic [MEM_AW-1:0]   ptr_q, ptr_d;
  logic [HI_BITS-1:0]  hi_q, hi_d;
  logic                rd_pend_q, rd_pend_d;
  logic                mnack_q, mnack_d;
  logic                oe_q, oe_d;
  logic                mem_we;
  logic [7:0]          mem_rdata;
  logic                sel_hit;

  smem_array #(.AW(MEM_AW)) u_array (
    .clk(clk), .we(mem_we), .addr(ptr_q), .wdata(rx_q), .rdata(mem_rdata)
  );

  assign sel_hit = (rx_q[7:4] == MEM_TYPE_CODE) && (rx_q[3:1] == sel_strap);

  always_comb begin
    phase_d   = phase_q;
    kind_d    = kind_q;
    cnt_d     = cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    ptr_d     = ptr_q;
    hi_d      = hi_q;
    rd_pend_d = rd_pend_q;
    mnack_d   = mnack_q;
    oe_d      = oe_q;
    mem_we    = 1'b0;
    if (cond_stop) begin
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
    end else if (cond_start) begin
      phase_d = PH_RX;
      kind_d  = K_SEL;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && cnt_q != BITS_PER_BYTE) begin
            rx_d  = {rx_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == BITS_PER_BYTE) begin
            phase_d = PH_RXACK;
            oe_d    = 1'b1;
            unique case (kind_q)
              K_SEL: begin
                if (sel_hit) begin
                  rd_pend_d = rx_q[0];
                  kind_d    = K_PHI;
                end else begin
                  phase_d = PH_IDLE;
                  oe_d    = 1'b0;
                end
              end
              K_PHI: begin
                hi_d   = rx_q[HI_BITS-1:0];
                kind_d = K_PLO;
              end
              K_PLO: begin
                ptr_d  = {hi_q, rx_q};
                kind_d = K_DATA;
              end
              default: begin
                mem_we = 1'b1;
                ptr_d  = ptr_q + PTR_ONE;
              end
            endcase
          end
        end
        PH_RXACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_pend_q) begin
              rd_pend_d = 1'b0;
              tx_d      = mem_rdata;
              ptr_d     = ptr_q + PTR_ONE;
              oe_d      = ~mem_rdata[7];
              phase_d   = PH_TX;
            end else begin
              oe_d    = 1'b0;
              phase_d = PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == BITS_PER_BYTE) begin
              oe_d    = 1'b0;
              phase_d = PH_TXACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
              oe_d = ~tx_q[6];
            end
          end
        end
        PH_TXACK: begin
          if (scl_rise) begin
            mnack_d = sda_s;
          end else if (scl_fall) begin
            if (mnack_q) begin
              phase_d = PH_IDLE;
            end else begin
              cnt_d   = '0;
              tx_d    = mem_rdata;
              ptr_d   = ptr_q + PTR_ONE;
              oe_d    = ~mem_rdata[7];
              phase_d = PH_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      kind_q    <= K_SEL;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      hi_q      <= '0;
      rd_pend_q <= 1'b0;
      mnack_q   <= 1'b1;
      oe_q      <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      kind_q    <= kind_d;
      cnt_q     <= cnt_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      ptr_q     <= ptr_d;
      hi_q      <= hi_d;
      rd_pend_q <= rd_pend_d;
      mnack_q   <= mnack_d;
      oe_q      <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> (!scl_s || $past(cond_start || cond_stop)));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !oe_q);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr_q == $past(ptr_q) + PTR_ONE));

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_start |=> (phase_q == PH_RX && kind_q == K_SEL && cnt_q == 4'd0));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_stop |=> (phase_q == PH_IDLE && !oe_q));

  // R8
  nack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TXACK && scl_fall && mnack_q && !cond_start && !cond_stop)
      |=> (phase_q == PH_IDLE));
endmodule

// File: tb/test_serial_mem_slave.sv
module test_serial_mem_slave;
  localparam int QC = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = 8'hAA;
  localparam logic [7:0] SEL_R = 8'hAB;
  // Vector: {write pointer, read pointer, data}; expected readback is data
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 8'h5A},
    {16'h0123, 16'h0123, 8'hC3},
    {16'hF456, 16'h0456, 8'h81},
    {16'h0ABC, 16'h3ABC, 8'h7E},
    {16'h0FFF, 16'h0FFF, 8'h00},
    {16'h0800, 16'h0800, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  int oe_cnt = 0;
  int r11_bad = 0;
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  serial_mem_slave i_serial_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sel_strap(STRAP), .sda_oe(sda_oe)
  );

  always @(posedge clk) begin
    prev_oe <= sda_oe;
    if (sda_oe) oe_cnt <= oe_cnt + 1;
    if (rst_n && (sda_oe !== prev_oe) && scl) r11_bad <= r11_bad + 1;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quarter;
    repeat (QC) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; quarter; scl = 1'b1; quarter; sda_m = 1'b0; quarter; scl = 1'b0;
  endtask

  task automatic bus_stop;
    quarter; sda_m = 1'b0; quarter; scl = 1'b1; quarter; sda_m = 1'b1; quarter;
  endtask

  task automatic send_bit(input logic b);
    quarter; sda_m = b; quarter; scl = 1'b1; quarter; quarter; scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    quarter; sda_m = 1'b1; quarter; scl = 1'b1; quarter;
    ack = ~sda_line;
    quarter; scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      quarter; quarter; scl = 1'b1; quarter;
      b[i] = sda_line;
      quarter; scl = 1'b0;
    end
    quarter; sda_m = ~give_ack; quarter; scl = 1'b1; quarter; quarter; scl = 1'b0;
    quarter; sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [15:0] a, output logic ok);
    logic k1, k2, k3;
    bus_start;
    send_byte(SEL_W, k1);
    send_byte(a[15:8], k2);
    send_byte(a[7:0], k3);
    ok = k1 & k2 & k3;
  endtask

  task automatic read_at(input logic [15:0] a, output logic [7:0] d, output logic ok);
    logic k1, k2;
    set_ptr(a, k1);
    bus_start;
    send_byte(SEL_R, k2);
    recv_byte(1'b0, d);
    bus_stop;
    ok = k1 & k2;
  endtask

  initial begin
    repeat (QC * 300000 / QC) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a1, a2, a3, a4, a5, ok;
    logic [7:0] d, d0, d1, d2;
    int snap;
    repeat (5) @(negedge clk);
    check("R1 sda_oe in reset", {15'd0, sda_oe}, 16'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 sda_oe after reset", {15'd0, sda_oe}, 16'd0);

    // Table walk: single byte write then random read (R2 R4 R5)
    for (int v = 0; v < NV; v++) begin
      bus_start;
      send_byte(SEL_W, a1);
      send_byte(VEC[v][39:32], a2);
      send_byte(VEC[v][31:24], a3);
      send_byte(VEC[v][7:0], a4);
      bus_stop;
      check("R2/R4 write acks", {12'd0, a1, a2, a3, a4}, 16'h000F);
      read_at(VEC[v][23:8], d, ok);
      check("R2 read acks", {15'd0, ok}, 16'd1);
      check("R4/R5 readback", {8'd0, d}, {8'd0, VEC[v][7:0]});
    end

    // R3 strap mismatch
    snap = oe_cnt;
    bus_start;
    send_byte(8'hA0, a1);
    send_byte(8'h12, a2);
    bus_stop;
    check("R3 strap mismatch ack", {14'd0, a1, a2}, 16'd0);
    check("R3 strap mismatch oe", 16'(oe_cnt - snap), 16'd0);
    // R3 type mismatch
    snap = oe_cnt;
    bus_start;
    send_byte(8'hBA, a1);
    bus_stop;
    check("R3 type mismatch ack", {15'd0, a1}, 16'd0);
    check("R3 type mismatch oe", 16'(oe_cnt - snap), 16'd0);

    // R10 bytes after STOP without START
    snap = oe_cnt;
    send_byte(SEL_W, a1);
    bus_stop;
    check("R10 no ack after stop", {15'd0, a1}, 16'd0);
    check("R10 oe after stop", 16'(oe_cnt - snap), 16'd0);

    // R6 sequential write across the wrap, R7 current read
    bus_start; send_byte(SEL_W, a1); send_byte(8'h00, a2); send_byte(8'h01, a3);
    send_byte(8'h44, a4); bus_stop;
    check("R4 write 0x001 acks", {12'd0, a1, a2, a3, a4}, 16'h000F);
    bus_start; send_byte(SEL_W, a1); send_byte(8'h0F, a2); send_byte(8'hFE, a3);
    send_byte(8'h11, a4); send_byte(8'h22, a5); send_byte(8'h33, ok); bus_stop;
    check("R6 seq write acks", {10'd0, a1, a2, a3, a4, a5, ok}, 16'h003F);
    read_at(16'h0000, d, ok);
    check("R6 write wrap to 0", {8'd0, d}, 16'h0033);
    set_ptr(16'h0FFE, ok);
    bus_start; send_byte(SEL_R, a1);
    recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2);
    bus_stop;
    check("R6/R8 seq read", {8'd0, d0}, 16'h0011);
    check("R6/R8 seq read", {8'd0, d1}, 16'h0022);
    check("R6 seq read wrap", {8'd0, d2}, 16'h0033);
    bus_start; send_byte(SEL_R, a1); recv_byte(1'b0, d); bus_stop;
    check("R7 current read ack", {15'd0, a1}, 16'd1);
    check("R7 current read data", {8'd0, d}, 16'h0044);

    // R8 NACK ends read
    set_ptr(16'h0800, ok);
    bus_start; send_byte(SEL_R, a1); recv_byte(1'b0, d);
    snap = oe_cnt;
    recv_byte(1'b0, d1);
    bus_stop;
    check("R8 data before nack", {8'd0, d}, 16'h00FF);
    check("R8 released after nack", 16'(oe_cnt - snap), 16'd0);
    check("R8 line idle after nack", {8'd0, d1}, 16'h00FF);

    // R9 repeated START mid-byte
    set_ptr(16'h0123, ok);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start;
    send_byte(SEL_R, a1);
    recv_byte(1'b0, d);
    bus_stop;
    check("R9 restart ack", {15'd0, a1}, 16'd1);
    check("R9 aborted byte not stored", {8'd0, d}, 16'h00C3);

    check("R11 oe changes with scl high", 16'(r11_bad), 16'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule